// File: doc/BRIEF.md
# DDR Byte Lane Clock and Data Path

This block sits between a memory command controller and the pins of an 8-bit double-data-rate memory device. It is clocked by a system clock running at twice the memory clock rate. Every system-clock cycle is one half period of the memory clock, and so one data beat on the bus. The block produces the memory clock pair from two toggle registers. It turns each 16-bit internal write word into two bus bytes, with a strobe, and it packs two read bytes back into one 16-bit word.

The controller frames a write with a level write enable. The first two cycles of the frame form a strobe preamble, which lasts one memory clock. After that, each pair of cycles moves one word: the upper byte goes out first. The strobe is high during the upper byte and low during the lower byte, and that low beat also serves as the postamble. When the frame ends, both the data drivers and the strobe drivers release the bus. A read is framed the same way with a read enable. Incoming bytes are captured on system-clock enables rather than on the incoming strobe. The quarter-cycle placement of the write strobe and the read sampling point belong to the pad delays outside this block.

Top module: `ddr_beat_phy`

## Requirements
- R1: While reset is high, mem_ck is 0 and mem_ck_n is 1. After reset, both outputs invert on every system-clock edge, and mem_ck_n is always the complement of mem_ck.
- R2: While reset is high, dq_oe, dqs_oe, dqs_out, dq_out, rd_valid and rd_word are all 0.
- R3: In the first two cycles after wr_en is first sampled high, dqs_oe is 1, dqs_out is 0, dq_oe is 0 and dq_out is 0. This is the preamble. All outputs are registered, so each reflects the inputs sampled at the previous edge.
- R4: After the preamble, while wr_en stays high, the data beats alternate. On each upper beat, dq_out carries wr_word[15:8] of the word sampled at that edge. The beat after it carries wr_word[7:0] of that same word. dq_oe is 1 on every data beat.
- R5: dqs_out is 1 on each upper-byte beat and 0 on each lower-byte beat, so it toggles once per data beat.
- R6: In the cycle after wr_en is sampled low, dq_oe and dqs_oe are both 0. A frame cut short in the preamble or after an upper beat drops the rest of its word.
- R7: With rd_en high and wr_en low, the first sampled dq_in byte goes to rd_word[15:8] and the next goes to rd_word[7:0]. rd_valid is 1 for exactly the cycle in which the lower byte appears. Consecutive beat pairs form consecutive words.
- R8: While wr_en is high, rd_en is ignored: nothing is captured, rd_valid stays 0 and rd_word holds its value. Whenever capture stops, the next captured byte goes to the upper half again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the memory clock rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write frame enable, held for preamble plus data beats |
| wr_word | input | 16 | Write word, sampled on each upper-byte beat |
| rd_en | input | 1 | Read frame enable, one cycle per incoming byte |
| dq_in | input | 8 | Data bus value seen at the pins |
| mem_ck | output | 1 | Memory clock |
| mem_ck_n | output | 1 | Complementary memory clock |
| dq_out | output | 8 | Data bus drive value |
| dq_oe | output | 1 | Data bus output enable |
| dqs_out | output | 1 | Strobe drive value |
| dqs_oe | output | 1 | Strobe output enable |
| rd_word | output | 16 | Assembled read word |
| rd_valid | output | 1 | One-cycle pulse when rd_word is complete |

## Verification
Some properties hold on every cycle, and the assertions check them there. The clock pair stays complementary and toggles each cycle. Both bus drivers are released one cycle after the write enable drops. The data enable never rises without the strobe enable. Data beats start with the strobe high and flip it on each later beat. A read word is flagged only after a read cycle that no write overlapped. The byte contents need the bench's reference model: upper-before-lower ordering, the length of the preamble, where a word is dropped by an aborted frame, and where read bytes land after a broken or overlapped read.

// File: rtl/ddr_beat_pkg.sv
package ddr_beat_pkg;

    // Phase of the write serializer; one phase per system-clock beat.
    typedef enum logic [1:0] {
        WP_IDLE = 2'd0,
        WP_PRE  = 2'd1,
        WP_HI   = 2'd2,
        WP_LO   = 2'd3
    } wr_phase_e;

    // Memory clock pair as produced by the two toggle registers.
    typedef struct packed {
        logic ck;
        logic ck_n;
    } ck_pair_t;

    localparam ck_pair_t CK_PAIR_RESET = '{ck: 1'b0, ck_n: 1'b1};

    function automatic logic is_data_phase(input wr_phase_e ph);
        return (ph == WP_HI) || (ph == WP_LO);
    endfunction

    function automatic ck_pair_t ck_pair_flip(input ck_pair_t p);
        ck_pair_t r;
        r.ck   = ~p.ck;
        r.ck_n = ~p.ck_n;
        return r;
    endfunction

endpackage

// File: rtl/ddr_ck_gen.sv
module ddr_ck_gen
    import ddr_beat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic mem_ck,
    output logic mem_ck_n
);

    ck_pair_t pair_q;

    always_ff @(posedge clk) begin
        if (rst) pair_q <= CK_PAIR_RESET;
        else     pair_q <= ck_pair_flip(pair_q);
    end

    assign mem_ck   = pair_q.ck;
    assign mem_ck_n = pair_q.ck_n;

endmodule

// File: rtl/ddr_wr_serializer.sv
module ddr_wr_serializer
    import ddr_beat_pkg::*;
#(
    parameter int DQ_W      = 8,
    parameter int PRE_BEATS = 2,
    localparam int WORD_W   = 2 * DQ_W,
    localparam int PCW      = $clog2(PRE_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              dqs_out,
    output logic              dqs_oe
);

    wr_phase_e       phase_q, phase_d;
    logic [PCW-1:0]  pre_cnt_q, pre_cnt_d;
    logic [DQ_W-1:0] lo_byte_q;
    logic [DQ_W-1:0] dq_q;
    logic            dqs_q;

    always_comb begin
        phase_d   = phase_q;
        pre_cnt_d = pre_cnt_q;
        if (!wr_en) begin
            phase_d   = WP_IDLE;
            pre_cnt_d = '0;
        end else begin
            unique case (phase_q)
                WP_IDLE: begin
                    phase_d   = WP_PRE;
                    pre_cnt_d = PCW'(1);
                end
                WP_PRE: begin
                    if (pre_cnt_q == PCW'(PRE_BEATS)) begin
                        phase_d = WP_HI;
                    end else begin
                        pre_cnt_d = pre_cnt_q + PCW'(1);
                    end
                end
                WP_HI:   phase_d = WP_LO;
                WP_LO:   phase_d = WP_HI;
                default: phase_d = WP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= WP_IDLE;
            pre_cnt_q <= '0;
            lo_byte_q <= '0;
            dq_q      <= '0;
            dqs_q     <= 1'b0;
        end else begin
            phase_q   <= phase_d;
            pre_cnt_q <= pre_cnt_d;
            // strobe toggles once per data beat, rests low otherwise
            dqs_q     <= is_data_phase(phase_d) ? ~dqs_q : 1'b0;
            if (phase_d == WP_HI) begin
                dq_q      <= wr_word[WORD_W-1 -: DQ_W];
                lo_byte_q <= wr_word[DQ_W-1:0];
            end else if (phase_d == WP_LO) begin
                dq_q      <= lo_byte_q;
            end else begin
                dq_q      <= '0;
            end
        end
    end

    assign dq_out  = dq_q;
    assign dqs_out = dqs_q;
    assign dq_oe   = is_data_phase(phase_q);
    assign dqs_oe  = (phase_q != WP_IDLE);

endmodule

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture #(
    parameter int DQ_W    = 8,
    localparam int WORD_W = 2 * DQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_valid
);

    logic              lower_next_q;
    logic [WORD_W-1:0] word_q;
    logic              valid_q;
    logic              cap_en;

    assign cap_en = rd_en && !wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            lower_next_q <= 1'b0;
            word_q       <= '0;
            valid_q      <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (cap_en) begin
                lower_next_q <= ~lower_next_q;
                if (!lower_next_q) begin
                    word_q[WORD_W-1 -: DQ_W] <= dq_in;
                end else begin
                    word_q[DQ_W-1:0] <= dq_in;
                    valid_q          <= 1'b1;
                end
            end else begin
                lower_next_q <= 1'b0;
            end
        end
    end

    assign rd_word  = word_q;
    assign rd_valid = valid_q;

endmodule

// File: rtl/ddr_beat_phy.sv
module ddr_beat_phy #(
    parameter int DQ_W      = 8,
    parameter int PRE_BEATS = 2,
    localparam int WORD_W   = 2 * DQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [DQ_W-1:0]   dq_in,
    output logic              mem_ck,
    output logic              mem_ck_n,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              dqs_out,
    output logic              dqs_oe,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_valid
);

    ddr_ck_gen u_ck_gen (
        .clk      (clk),
        .rst      (rst),
        .mem_ck   (mem_ck),
        .mem_ck_n (mem_ck_n)
    );

    ddr_wr_serializer #(
        .DQ_W      (DQ_W),
        .PRE_BEATS (PRE_BEATS)
    ) u_wr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe),
        .dqs_out (dqs_out),
        .dqs_oe  (dqs_oe)
    );

    ddr_rd_capture #(
        .DQ_W (DQ_W)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .dq_in    (dq_in),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/ddr_beat_phy_chk.sv
module ddr_beat_phy_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic rd_en,
    input logic mem_ck,
    input logic mem_ck_n,
    input logic dq_oe,
    input logic dqs_oe,
    input logic dqs_out,
    input logic rd_valid
);

    logic past_ok;

    always_ff @(posedge clk) past_ok <= !rst;

    // R1
    ck_pair_compl_chk: assert property (@(posedge clk) disable iff (rst)
        mem_ck_n == !mem_ck);

    // R1
    ck_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (mem_ck != $past(mem_ck)));

    // R6
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(wr_en)) |-> (!dq_oe && !dqs_oe));

    // R3
    dq_under_dqs_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> dqs_oe);

    // R5
    first_beat_high_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && dq_oe && !$past(dq_oe)) |-> dqs_out);

    // R5
    dqs_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && dq_oe && $past(dq_oe)) |-> (dqs_out != $past(dqs_out)));

    // R7
    valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && rd_valid) |-> ($past(rd_en) && !$past(wr_en)));

    // R8
    no_read_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wr_en)) |-> !rd_valid);

endmodule

bind ddr_beat_phy ddr_beat_phy_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .mem_ck   (mem_ck),
    .mem_ck_n (mem_ck_n),
    .dq_oe    (dq_oe),
    .dqs_oe   (dqs_oe),
    .dqs_out  (dqs_out),
    .rd_valid (rd_valid)
);

// File: tb/ddr_beat_phy_bench.sv
module ddr_beat_phy_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_word = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  dq_in = '0;
    logic        mem_ck, mem_ck_n, dq_oe, dqs_out, dqs_oe, rd_valid;
    logic [7:0]  dq_out;
    logic [15:0] rd_word;

    always #2.5 clk = ~clk;

    ddr_beat_phy u_ddr_beat_phy (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
        .rd_en(rd_en), .dq_in(dq_in), .mem_ck(mem_ck), .mem_ck_n(mem_ck_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dqs_out(dqs_out), .dqs_oe(dqs_oe),
        .rd_word(rd_word), .rd_valid(rd_valid)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural reference: beat counters and a queue of pending low bytes
    int         wn = 0, rn = 0;
    logic [7:0] lo_q[$];
    logic       e_ck, e_dq_oe, e_dqs, e_dqs_oe, e_valid;
    logic [7:0] e_dq;
    logic [15:0] e_rd;

    always @(posedge clk) begin
        if (rst) begin
            e_ck = 0; e_dq_oe = 0; e_dqs = 0; e_dqs_oe = 0; e_dq = 0;
            e_valid = 0; e_rd = 0; wn = 0; rn = 0; lo_q.delete();
        end else begin
            e_ck = !e_ck;
            if (wr_en) begin
                wn++;
                e_dqs_oe = 1;
                if (wn <= 2) begin
                    e_dq_oe = 0; e_dqs = 0; e_dq = 0;
                end else if (((wn - 3) % 2) == 0) begin
                    e_dq_oe = 1; e_dqs = 1; e_dq = wr_word[15:8];
                    lo_q.delete(); lo_q.push_back(wr_word[7:0]);
                end else begin
                    e_dq_oe = 1; e_dqs = 0; e_dq = lo_q.pop_front();
                end
            end else begin
                wn = 0; e_dqs_oe = 0; e_dq_oe = 0; e_dqs = 0; e_dq = 0;
            end
            e_valid = 0;
            if (rd_en && !wr_en) begin
                rn++;
                if (rn % 2 == 1) e_rd[15:8] = dq_in;
                else begin e_rd[7:0] = dq_in; e_valid = 1; end
            end else begin
                rn = 0;
            end
        end
    end

    task automatic cmp(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        cmp("R1", "mem_ck",   16'(mem_ck),   16'(e_ck));
        cmp("R1", "mem_ck_n", 16'(mem_ck_n), 16'(!e_ck));
        cmp(rst ? "R2" : "R3", "dqs_oe", 16'(dqs_oe), 16'(e_dqs_oe));
        cmp(rst ? "R2" : "R6", "dq_oe",  16'(dq_oe),  16'(e_dq_oe));
        cmp(rst ? "R2" : "R5", "dqs_out", 16'(dqs_out), 16'(e_dqs));
        cmp(rst ? "R2" : "R4", "dq_out",  16'(dq_out),  16'(e_dq));
        cmp(rst ? "R2" : "R7", "rd_valid", 16'(rd_valid), 16'(e_valid));
        cmp(rst ? "R2" : "R8", "rd_word",  rd_word, e_rd);
    endtask

    // check at the falling edge, then drive the next inputs
    task automatic step(input logic w, input logic r, input logic [15:0] wd, input logic [7:0] d);
        @(negedge clk);
        check_all();
        wr_en = w; rd_en = r; wr_word = wd; dq_in = d;
    endtask

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        repeat (3) begin @(negedge clk); check_all(); end   // R2 reset state
        rst = 0;
        step(0, 0, 16'h0000, 8'h00);
        // R3 R4 R5: one word framed by preamble
        step(1, 0, 16'h1111, 8'h00);
        step(1, 0, 16'h2222, 8'h00);
        step(1, 0, 16'hA55A, 8'h00);
        step(1, 0, 16'hFFFF, 8'h00);
        step(0, 0, 16'h0000, 8'h00);
        step(0, 0, 16'h0000, 8'h00);
        // R4: three back-to-back words
        step(1, 0, 16'h0, 8'h0); step(1, 0, 16'h0, 8'h0);
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 16'h1234 + 16'(i) * 16'h1111, 8'h0);
            step(1, 0, 16'h0BAD, 8'h0);
        end
        step(0, 0, 16'h0, 8'h0);
        // R6: aborted in preamble, then after an upper beat
        step(1, 0, 16'h0, 8'h0); step(0, 0, 16'h0, 8'h0);
        step(1, 0, 16'h0, 8'h0); step(1, 0, 16'h0, 8'h0);
        step(1, 0, 16'hC3D4, 8'h0); step(0, 0, 16'h0, 8'h0);
        step(0, 0, 16'h0, 8'h0);
        // R7: one word, then three words
        step(0, 1, 16'h0, 8'h9A); step(0, 1, 16'h0, 8'hBC);
        step(0, 0, 16'h0, 8'h00);
        for (int i = 0; i < 6; i++) step(0, 1, 16'h0, 8'(8'h10 + i));
        step(0, 0, 16'h0, 8'h00);
        // R8: odd-length read restarts, read ignored under write
        step(0, 1, 16'h0, 8'h77); step(0, 0, 16'h0, 8'h00);
        step(0, 1, 16'h0, 8'h88); step(1, 1, 16'h4444, 8'h99);
        step(1, 1, 16'h5555, 8'h66); step(0, 1, 16'h0, 8'h21);
        step(0, 1, 16'h0, 8'h43); step(0, 0, 16'h0, 8'h00);
        // mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[3] & lf[7] | (wn > 0 && lf[1]), lf[5], lf ^ 16'h3C5A, lf[15:8]);
        end
        step(0, 0, 16'h0, 8'h0);
        step(0, 0, 16'h0, 8'h0);
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule